// File: doc/BRIEF.md
# Paged processor access decoder for a time-slot switch

This block is the 8-bit processor side of a time-slot interchange switch. It holds one control register and uses six address lines together with that register to route each processor access. An access with the top address line low reaches the control register. An access with the top address line high reaches one of three memories: the data memory, the low connection memory or the high connection memory. The register chooses the memory and a stream number (0-7). The five low address lines choose a channel (0-31) within that stream. A split mode makes every paged read come from the data memory and every paged write go to the low connection memory, whatever the memory select holds. The register also supplies a global message-mode flag to the switch core.

The memories belong to the switch core and are shared with its frame-rate traffic. The decoder drives their address, write data and per-memory read and write strobes. It fires a strobe only in a cycle that the core leaves free, as shown by `core_use` being low. The processor side uses a simple synchronous handshake. A one-cycle `host_req` starts an access. `host_busy` stays high until the access ends, and `host_done` pulses once when it ends. Read data is valid together with `host_done`.

Top module: `host_page_decoder`

## Requirements
- R1: After reset the control register reads as 0x00, `msg_mode` is 0, `host_busy` and `host_done` are 0 and no memory strobe is active.
- R2: When `host_addr[5]` is 0 the access reads or writes the full control register, whatever `host_addr[4:0]` holds. A read returns the last value written.
- R3: `msg_mode` equals control register bit 6. Bit 5 is stored and read back but affects nothing.
- R4: For a paged access (`host_addr[5]`=1), `mem_addr` is {control bits 2:0, `host_addr[4:0]`}. `mem_wdata` carries the write data.
- R5: With split off, select bits 4:3 = 10 read and write the low connection memory, and 11 read and write the high connection memory.
- R6: Select 01 reads the data memory. A write with select 01 fires no strobe and leaves all memories unchanged, but it still completes with `host_done`.
- R7: Select 00 reads return 0x00. Writes with select 00 fire no strobe and still complete.
- R8: When control bit 7 is 1, paged reads come from the data memory and paged writes go to the low connection memory, whatever bits 4:3 hold. The stream bits still form the address.
- R9: A memory strobe is active only in a cycle where `core_use` is 0. While `core_use` stays 1 the access waits, with `host_busy` high, and no `host_done`.
- R10: `host_req` is taken only when the block is idle. A request made while busy is ignored. `host_done` is a one-cycle pulse. A control register access shows `host_done` in the first cycle after the request edge.
- R11: A granted memory read latches the selected memory's data one cycle after the read strobe. `host_rdata` shows it with `host_done` two cycles after the grant edge when `core_use` is free. A granted write completes one cycle after the grant edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | One-cycle access request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 6 | Bit 5 page/register select, bits 4:0 channel |
| host_wdata | input | 8 | Processor write data |
| host_rdata | output | 8 | Read result, valid with host_done |
| host_busy | output | 1 | Access in progress |
| host_done | output | 1 | Access complete pulse |
| msg_mode | output | 1 | Global message-mode flag to the core |
| core_use | input | 1 | Core occupies the memory port this cycle |
| mem_addr | output | 8 | Memory index {stream, channel} |
| mem_wdata | output | 8 | Memory write data |
| dm_rd | output | 1 | Data memory read strobe |
| dm_rdata | input | 8 | Data memory read data, one cycle after strobe |
| cml_rd | output | 1 | Low connection memory read strobe |
| cml_wr | output | 1 | Low connection memory write strobe |
| cml_rdata | input | 8 | Low connection memory read data |
| cmh_rd | output | 1 | High connection memory read strobe |
| cmh_wr | output | 1 | High connection memory write strobe |
| cmh_rdata | input | 8 | High connection memory read data |

## Verification
Two things can fall in the same cycle. One is a pending processor memory access and the core's claim on the memory port. The other is a new processor request and an access that is still in flight. The bench holds `core_use` high across a pending write and pulses a control register write into that window. It then judges three things: no strobe appears while the port is claimed, the stray request leaves the register unchanged, and the held access finishes at the right address once the port frees. Random phases also toggle `core_use` randomly under a mix of accesses. A strobe seen together with `core_use` counts as a failure, and every read result is compared with a shadow model of the register and memories.

// File: rtl/hpd_pkg.sv
package hpd_pkg;
  typedef enum logic [2:0] {
    TGT_CR   = 3'd0,
    TGT_DM   = 3'd1,
    TGT_CML  = 3'd2,
    TGT_CMH  = 3'd3,
    TGT_NONE = 3'd4
  } tgt_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PEND = 2'd1,
    ST_RLAT = 2'd2,
    ST_FIN  = 2'd3
  } st_e;
endpackage

// File: rtl/hpd_ctrl_reg.sv
module hpd_ctrl_reg
  import hpd_pkg::*;
#(
  parameter int DW   = 8,
  parameter int ST_W = 3,
  parameter int AW   = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic          host_we,
  input  logic          page_sel,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] cr_q,
  output logic          msg_mode,
  output logic [ST_W-1:0] stream,
  output tgt_e          tgt
);
  localparam int SPLIT_BIT = DW - 1;
  localparam int MSG_BIT   = DW - 2;
  localparam int SEL_LO    = ST_W;

  logic cr_wr;
  assign cr_wr = accept && host_we && !page_sel;

  always_ff @(posedge clk) begin
    if (rst) cr_q <= '0;
    else if (cr_wr) cr_q <= host_wdata;
  end

  assign msg_mode = cr_q[MSG_BIT];
  assign stream   = cr_q[ST_W-1:0];

  // Target decode from page line, split flag and memory select
  always_comb begin
    if (!page_sel) begin
      tgt = TGT_CR;
    end else if (cr_q[SPLIT_BIT]) begin
      tgt = host_we ? TGT_CML : TGT_DM;
    end else begin
      case (cr_q[SEL_LO+1:SEL_LO])
        2'b01:   tgt = host_we ? TGT_NONE : TGT_DM;
        2'b10:   tgt = TGT_CML;
        2'b11:   tgt = TGT_CMH;
        default: tgt = TGT_NONE;
      endcase
    end
  end

  // Register only changes on a register-page write (R2)
  p_cr_page0_only_r2: assert property (@(posedge clk) disable iff (rst)
    !(accept && host_we && !page_sel) |=> $stable(cr_q));

  // Unused-width guard
  initial assert (AW >= 2 && DW >= ST_W + 4);
endmodule

// File: rtl/hpd_arbiter.sv
module hpd_arbiter
  import hpd_pkg::*;
#(
  parameter int DW  = 8,
  parameter int MAW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           host_req,
  input  logic           host_we,
  input  tgt_e           tgt,
  input  logic [MAW-1:0] mem_idx,
  input  logic [DW-1:0]  host_wdata,
  input  logic           core_use,
  output logic           accept,
  output logic           busy,
  output logic           done,
  output logic           in_rlat,
  output tgt_e           pend_tgt,
  output logic [MAW-1:0] mem_addr,
  output logic [DW-1:0]  mem_wdata,
  output logic           dm_rd,
  output logic           cml_rd,
  output logic           cml_wr,
  output logic           cmh_rd,
  output logic           cmh_wr
);
  st_e  state;
  logic pend_we;
  logic grant;

  assign accept  = (state == ST_IDLE) && host_req;
  assign grant   = (state == ST_PEND) && !core_use;
  assign busy    = (state != ST_IDLE);
  assign done    = (state == ST_FIN);
  assign in_rlat = (state == ST_RLAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      pend_tgt  <= TGT_NONE;
      pend_we   <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      case (state)
        ST_IDLE: if (host_req) begin
          pend_tgt  <= tgt;
          pend_we   <= host_we;
          mem_addr  <= mem_idx;
          mem_wdata <= host_wdata;
          if (tgt == TGT_CR || tgt == TGT_NONE) state <= ST_FIN;
          else                                  state <= ST_PEND;
        end
        ST_PEND: if (!core_use) state <= pend_we ? ST_FIN : ST_RLAT;
        ST_RLAT: state <= ST_FIN;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign dm_rd  = grant && !pend_we && (pend_tgt == TGT_DM);
  assign cml_rd = grant && !pend_we && (pend_tgt == TGT_CML);
  assign cml_wr = grant &&  pend_we && (pend_tgt == TGT_CML);
  assign cmh_rd = grant && !pend_we && (pend_tgt == TGT_CMH);
  assign cmh_wr = grant &&  pend_we && (pend_tgt == TGT_CMH);

  p_core_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
    (dm_rd || cml_rd || cml_wr || cmh_rd || cmh_wr) |-> !core_use);

  p_single_strobe_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({dm_rd, cml_rd, cml_wr, cmh_rd, cmh_wr}));

  p_wait_holds_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && !done && !in_rlat && core_use) |=> (busy && !done));

  p_addr_held_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> $stable(mem_addr));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/hpd_rdmux.sv
module hpd_rdmux
  import hpd_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic          host_we,
  input  tgt_e          tgt,
  input  logic [DW-1:0] cr_q,
  input  logic          in_rlat,
  input  tgt_e          pend_tgt,
  input  logic [DW-1:0] dm_rdata,
  input  logic [DW-1:0] cml_rdata,
  input  logic [DW-1:0] cmh_rdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem_sel;

  always_comb begin
    case (pend_tgt)
      TGT_DM:  mem_sel = dm_rdata;
      TGT_CML: mem_sel = cml_rdata;
      TGT_CMH: mem_sel = cmh_rdata;
      default: mem_sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (accept && !host_we && tgt == TGT_CR) begin
      rdata <= cr_q;
    end else if (accept && !host_we && tgt == TGT_NONE) begin
      rdata <= '0;
    end else if (in_rlat) begin
      rdata <= mem_sel;
    end
  end
endmodule

// File: rtl/host_page_decoder.sv
module host_page_decoder
  import hpd_pkg::*;
#(
  parameter int DW   = 8,
  parameter int CH_W = 5,
  parameter int ST_W = 3,
  localparam int AW  = CH_W + 1,
  localparam int MAW = ST_W + CH_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           host_req,
  input  logic           host_we,
  input  logic [AW-1:0]  host_addr,
  input  logic [DW-1:0]  host_wdata,
  output logic [DW-1:0]  host_rdata,
  output logic           host_busy,
  output logic           host_done,
  output logic           msg_mode,
  input  logic           core_use,
  output logic [MAW-1:0] mem_addr,
  output logic [DW-1:0]  mem_wdata,
  output logic           dm_rd,
  input  logic [DW-1:0]  dm_rdata,
  output logic           cml_rd,
  output logic           cml_wr,
  input  logic [DW-1:0]  cml_rdata,
  output logic           cmh_rd,
  output logic           cmh_wr,
  input  logic [DW-1:0]  cmh_rdata
);
  logic [DW-1:0]   cr_q;
  logic [ST_W-1:0] stream;
  logic [MAW-1:0]  mem_idx;
  logic            accept, in_rlat;
  tgt_e            tgt, pend_tgt;

  assign mem_idx = {stream, host_addr[CH_W-1:0]};

  hpd_ctrl_reg #(.DW(DW), .ST_W(ST_W), .AW(AW)) u_cr (
    .clk(clk), .rst(rst), .accept(accept), .host_we(host_we),
    .page_sel(host_addr[AW-1]), .host_wdata(host_wdata),
    .cr_q(cr_q), .msg_mode(msg_mode), .stream(stream), .tgt(tgt)
  );

  hpd_arbiter #(.DW(DW), .MAW(MAW)) u_arb (
    .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we),
    .tgt(tgt), .mem_idx(mem_idx), .host_wdata(host_wdata),
    .core_use(core_use), .accept(accept), .busy(host_busy),
    .done(host_done), .in_rlat(in_rlat), .pend_tgt(pend_tgt),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .dm_rd(dm_rd), .cml_rd(cml_rd), .cml_wr(cml_wr),
    .cmh_rd(cmh_rd), .cmh_wr(cmh_wr)
  );

  hpd_rdmux #(.DW(DW)) u_rd (
    .clk(clk), .rst(rst), .accept(accept), .host_we(host_we),
    .tgt(tgt), .cr_q(cr_q), .in_rlat(in_rlat), .pend_tgt(pend_tgt),
    .dm_rdata(dm_rdata), .cml_rdata(cml_rdata), .cmh_rdata(cmh_rdata),
    .rdata(host_rdata)
  );

  // Message flag follows register bit 6 one cycle after a register write (R3)
  p_msg_follows_r3: assert property (@(posedge clk) disable iff (rst)
    (host_req && !host_busy && host_we && !host_addr[AW-1])
      |=> (msg_mode == $past(host_wdata[DW-2])));
endmodule

// File: tb/sim_host_page_decoder.sv
module sim_host_page_decoder;
  localparam int CLK_P = 10;

  logic       clk = 0, rst = 1;
  logic       host_req = 0, host_we = 0, core_use = 0;
  logic [5:0] host_addr = 0;
  logic [7:0] host_wdata = 0;
  logic [7:0] host_rdata, mem_wdata, dm_rdata, cml_rdata, cmh_rdata;
  logic [7:0] mem_addr;
  logic       host_busy, host_done, msg_mode;
  logic       dm_rd, cml_rd, cml_wr, cmh_rd, cmh_wr;

  host_page_decoder u0 (.*);

  always #(CLK_P/2) clk = ~clk;

  logic [7:0] dm_m [256];
  logic [7:0] cml_m [256];
  logic [7:0] cmh_m [256];
  logic [7:0] sh_cml [256];
  logic [7:0] sh_cmh [256];
  logic [7:0] exp_cr;
  int n_chk = 0, n_bad = 0, n_wr = 0, n_clash = 0, cyc = 0, core_mode = 0;
  logic [7:0] last_wr_addr;

  function automatic logic [7:0] dm_init(int i);
    return 8'((i * 13 + 5) & 8'hFF);
  endfunction

  // 0 reg, 1 dm, 2 cml, 3 cmh, 4 none
  function automatic int exp_tgt(logic [7:0] cr, logic [5:0] a, logic we);
    if (!a[5]) return 0;
    if (cr[7]) return we ? 2 : 1;
    case (cr[4:3])
      2'b01: return we ? 4 : 1;
      2'b10: return 2;
      2'b11: return 3;
      default: return 4;
    endcase
  endfunction

  // Memory model owned by the core side
  always @(posedge clk) begin
    if (cml_wr) cml_m[mem_addr] <= mem_wdata;
    if (cmh_wr) cmh_m[mem_addr] <= mem_wdata;
    if (dm_rd)  dm_rdata  <= dm_m[mem_addr];
    if (cml_rd) cml_rdata <= cml_m[mem_addr];
    if (cmh_rd) cmh_rdata <= cmh_m[mem_addr];
  end

  // Monitor between edges
  always @(negedge clk) begin
    if (!rst) begin
      if ((dm_rd | cml_rd | cml_wr | cmh_rd | cmh_wr) && core_use) n_clash++;
      if (cml_wr | cmh_wr) begin n_wr++; last_wr_addr = mem_addr; end
    end
  end

  // Core port usage changes just after each edge
  always @(posedge clk) begin
    cyc++;
    #1;
    case (core_mode)
      1: core_use = 1;
      2: core_use = 0;
      default: core_use = ($urandom % 100) < 40;
    endcase
  end

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic host_op(input logic we, input logic [5:0] a, input logic [7:0] wd,
                         output logic [7:0] rd, output int lat);
    @(negedge clk);
    host_req = 1; host_we = we; host_addr = a; host_wdata = wd;
    @(negedge clk);
    host_req = 0;
    lat = 0;
    while (!host_done && lat < 1000) begin @(negedge clk); lat++; end
    rd = host_rdata;
  endtask

  // Operation with model update and read check
  task automatic op_chk(input logic we, input logic [5:0] a, input logic [7:0] wd, string tag);
    logic [7:0] rd, ev;
    int t, lat;
    logic [7:0] idx;
    t = exp_tgt(exp_cr, a, we);
    idx = {exp_cr[2:0], a[4:0]};
    ev = 0;
    case (t)
      0: ev = exp_cr;
      1: ev = dm_init(idx);
      2: ev = sh_cml[idx];
      3: ev = sh_cmh[idx];
      default: ev = 0;
    endcase
    host_op(we, a, wd, rd, lat);
    if (we) begin
      if (t == 0) exp_cr = wd;
      if (t == 2) sh_cml[idx] = wd;
      if (t == 3) sh_cmh[idx] = wd;
      check(msg_mode == exp_cr[6], {tag, " R3 msg"}, msg_mode, exp_cr[6]);
    end else begin
      check(rd == ev, tag, rd, ev);
    end
  endtask

  initial begin
    logic [7:0] rd;
    int lat, w0;
    void'($urandom(32'd4711));
    for (int i = 0; i < 256; i++) begin
      dm_m[i] = dm_init(i); cml_m[i] = 0; cmh_m[i] = 0; sh_cml[i] = 0; sh_cmh[i] = 0;
    end
    exp_cr = 0;
    core_mode = 2;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check(!host_busy && !host_done && !msg_mode, "R1 idle flags", {host_busy, host_done, msg_mode}, 0);
    check(!(dm_rd | cml_rd | cml_wr | cmh_rd | cmh_wr), "R1 strobes", 1, 0);
    host_op(0, 6'h00, 0, rd, lat);
    check(rd == 0, "R1 reg read", rd, 0);
    check(lat == 0, "R10 reg latency", lat, 0);

    // R2 / R3 register page
    op_chk(1, 6'h1F, 8'h55, "R2 wr");
    op_chk(0, 6'h0A, 0, "R2 readback");
    check(msg_mode == 1, "R3 bit6 set", msg_mode, 1);
    op_chk(1, 6'h11, 8'h20, "R3 wr bit5");
    check(msg_mode == 0, "R3 bit5 no effect", msg_mode, 0);
    op_chk(0, 6'h00, 0, "R3 readback");

    // R4 / R5 low connection memory, stream 5
    op_chk(1, 6'h00, 8'h15, "R5 sel");
    host_op(1, 6'h27, 8'hA5, rd, lat);
    sh_cml[8'hA7] = 8'hA5;
    check(last_wr_addr == 8'hA7, "R4 addr", last_wr_addr, 8'hA7);
    check(lat == 1, "R11 write latency", lat, 1);
    host_op(0, 6'h27, 0, rd, lat);
    check(rd == 8'hA5, "R5 cml read", rd, 8'hA5);
    check(lat == 2, "R11 read latency", lat, 2);

    // R5 high connection memory, stream 2
    op_chk(1, 6'h00, 8'h1A, "R5 sel");
    op_chk(1, 6'h3F, 8'h3C, "R5 cmh wr");
    op_chk(0, 6'h3F, 0, "R5 cmh read");
    check(cml_m[8'h5F] == 0, "R5 cml untouched", cml_m[8'h5F], 0);

    // R6 data memory, stream 4
    op_chk(1, 6'h00, 8'h0C, "R6 sel");
    op_chk(0, 6'h29, 0, "R6 dm read");
    w0 = n_wr;
    op_chk(1, 6'h29, 8'hFF, "R6 dm wr");
    check(n_wr == w0, "R6 no write strobe", n_wr - w0, 0);
    op_chk(0, 6'h29, 0, "R6 dm unchanged");

    // R7 reserved select, stream 1
    op_chk(1, 6'h00, 8'h01, "R7 sel");
    op_chk(0, 6'h23, 0, "R7 read zero");
    w0 = n_wr;
    op_chk(1, 6'h23, 8'h99, "R7 wr");
    check(n_wr == w0, "R7 no write strobe", n_wr - w0, 0);

    // R8 split with select = high memory, stream 3
    op_chk(1, 6'h00, 8'h9B, "R8 sel");
    op_chk(1, 6'h24, 8'h77, "R8 split wr");
    check(cml_m[8'h64] == 8'h77, "R8 write to cml", cml_m[8'h64], 8'h77);
    check(cmh_m[8'h64] == 8'h00, "R8 cmh untouched", cmh_m[8'h64], 0);
    op_chk(0, 6'h24, 0, "R8 split reads dm");

    // R9 / R10 core holds the port, stray request while busy
    op_chk(1, 6'h00, 8'h12, "R9 sel");
    core_mode = 1;
    @(posedge clk); @(negedge clk);
    w0 = n_wr;
    host_req = 1; host_we = 1; host_addr = 6'h22; host_wdata = 8'h6E;
    @(negedge clk);
    host_req = 0;
    repeat (2) @(negedge clk);
    host_req = 1; host_we = 1; host_addr = 6'h00; host_wdata = 8'hEE;
    @(negedge clk);
    host_req = 0;
    repeat (4) @(negedge clk);
    check(host_busy && !host_done, "R9 waiting", {host_busy, host_done}, 2);
    check(n_wr == w0, "R9 no strobe while claimed", n_wr - w0, 0);
    core_mode = 2;
    lat = 0;
    while (!host_done && lat < 100) begin @(negedge clk); lat++; end
    check(host_done, "R9 completes", host_done, 1);
    check(last_wr_addr == 8'h42, "R9 addr after wait", last_wr_addr, 8'h42);
    sh_cml[8'h42] = 8'h6E;
    op_chk(0, 6'h00, 0, "R10 stray ignored");

    // Random phase with a randomly busy core
    core_mode = 0;
    for (int k = 0; k < 300; k++) begin
      int r;
      logic [7:0] v;
      r = $urandom % 10;
      v = 8'($urandom);
      if (r < 2) op_chk(1, {1'b0, 5'($urandom)}, v, "R2 rnd reg");
      else if (r < 3) op_chk(0, 6'h00, 0, "R2 rnd reg");
      else op_chk(r[0], {1'b1, 5'($urandom)}, v, "R11 rnd mem");
    end

    w0 = 0;
    for (int i = 0; i < 256; i++) if (cml_m[i] !== sh_cml[i]) w0++;
    check(w0 == 0, "R5 cml contents", w0, 0);
    w0 = 0;
    for (int i = 0; i < 256; i++) if (cmh_m[i] !== sh_cmh[i]) w0++;
    check(w0 == 0, "R5 cmh contents", w0, 0);
    check(n_clash == 0, "R9 strobe with core_use", n_clash, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog R10 actual=%0d expected=0", cyc);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule